// File: doc/BRIEF.md
# Programmable SDA Output Delay

This block sits between the serial engine and the SDA output pin of a two-wire serial port. It delays the outgoing SDA level by a programmable number of system clock cycles, which sets how long data is held after an SCL edge. The delay is chosen by a 3-bit code kept in the block's own control register.

The register can be reached only while the digital-delay enable input is high. While the enable is low, the register ignores writes, reads back as zero and has its code forced to zero. Code zero selects the undelayed path. That path stands in for an analog delay that lies outside this block.

An 8-stage shift line samples SDA on every clock and never stops. The code only chooses which tap drives the output. A new code therefore takes effect at the next clock edge and uses history that is already in the line.

Top module: `sda_delay_line`

## Requirements
- R1: The code is held in register bits [7:5]. With a nonzero code k, sda_out equals sda_in delayed by k+1 clock cycles. Code 1 gives 2 cycles and code 7 gives 8 cycles.
- R2: A write (reg_wr high at a clock edge) updates the code only while dig_en is high. A write made while dig_en is low leaves no trace, so a later read with dig_en high still returns the old cleared value.
- R3: Any clock edge at which dig_en is low clears the code to 0. Code 0 selects the bypass path.
- R4: After reset the code is 0, so a read with dig_en high returns 0x00.
- R5: Bits [4:0] of reg_rdata always read 0, even after a write that sets them.
- R6: While dig_en is low, reg_rdata is 0x00.
- R7: Only one path drives the output at a time. With code 0, sda_out follows sda_in within the same cycle and adds no clocked delay.
- R8: A code written at a clock edge selects its tap from that edge onward. The shift line keeps running whatever the code, so the first output after a change already carries the full new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_en | input | 1 | Digital-delay enable; unlocks the register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data; code taken from bits [7:5] |
| reg_rdata | output | 8 | Read data |
| sda_in | input | 1 | Undelayed SDA from the serial engine |
| sda_out | output | 1 | SDA toward the pin |

## Verification
The delay assertions assume sda_in is a clean level that changes at most once per clock, away from the edge. They also assume the line has seen at least eight edges since reset before its taps are compared with past inputs. The bench changes sda_in and the control inputs only at falling edges. It holds SDA high through reset, which matches the line's reset contents. The stimulus runs each code over a pseudo-random bit stream that is long enough to fill the whole line before any result is checked.

// File: rtl/sda_delay_line.sv
module sda_delay_line #(
  parameter int CODE_W = 3,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dig_en,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sda_in,
  output logic             sda_out
);
  localparam int CODE_LSB = REG_W - CODE_W;
  localparam int STAGES   = 1 << CODE_W;

  logic [CODE_W-1:0] code;
  logic [STAGES-1:0] line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code <= '0;
    else if (!dig_en)
      code <= '0;
    else if (reg_wr)
      code <= reg_wdata[REG_W-1:CODE_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= '1;
    else        line <= {line[STAGES-2:0], sda_in};
  end

  assign reg_rdata = dig_en ? {code, {CODE_LSB{1'b0}}} : '0;

  always_comb begin
    if (code == '0) sda_out = sda_in;
    else            sda_out = line[code];
  end

  logic [CODE_W:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     warm <= '0;
    else if (warm != (CODE_W+1)'(STAGES)) warm <= warm + 1'b1;
  end

  // R3
  code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_en |=> reg_rdata == '0 && $past(!dig_en));

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en && !reg_wr) |=> (!dig_en || $stable(reg_rdata)));

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[CODE_LSB-1:0] == '0);

  // R6
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dig_en |-> reg_rdata == '0);

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en && reg_rdata == '0) |-> sda_out == sda_in);

  // R1
  for (genvar k = 1; k < STAGES; k++) begin : g_tap_chk
    tap_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == (CODE_W+1)'(STAGES) && dig_en &&
       reg_rdata[REG_W-1:CODE_LSB] == CODE_W'(k))
      |-> sda_out == $past(sda_in, k + 1));
  end
endmodule

// File: tb/sda_delay_line_tb.sv
module sda_delay_line_tb;
  logic       clk = 0, rst_n = 0, dig_en = 0, reg_wr = 0, sda_in = 1;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sda_out;
  int checks = 0, fails = 0;
  bit done = 0;

  sda_delay_line u_dut (.clk, .rst_n, .dig_en, .reg_wr, .reg_wdata,
                        .reg_rdata, .sda_in, .sda_out);

  always #4 clk = ~clk;

  // {code, expected delay in cycles}; code 0 is bypass (R7), others R1
  localparam logic [7:0] VEC [8] = '{
    {3'd3, 5'd4}, {3'd0, 5'd0}, {3'd1, 5'd2}, {3'd7, 5'd8},
    {3'd5, 5'd6}, {3'd2, 5'd3}, {3'd6, 5'd7}, {3'd4, 5'd5}};

  logic hist [0:4095];
  int   t = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sda_in = lfsr[0];
    hist[t] = sda_in;
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R6 closed read", reg_rdata, 8'h00);
    dig_en = 1; #1;
    chk("R4 reset code", reg_rdata, 8'h00);
    chk("R7 reset bypass", {7'd0, sda_out}, {7'd0, sda_in});

    // R1 R7 R8: table walk; new tap valid right after the write edge
    for (int v = 0; v < 8; v++) begin
      logic [2:0] c = VEC[v][7:5];
      int d = int'(VEC[v][4:0]);
      @(negedge clk); reg_wr = 1; reg_wdata = {c, 5'b0};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sda_in = lfsr[0]; hist[t] = sda_in; t++;
      for (int i = 0; i < 24; i++) begin
        step();
        if (i == 0) begin reg_wr = 0; #1; end
        if (t >= 8)
          chk((d == 0) ? "R7 bypass" : (i == 0 ? "R8 first tap" : "R1 delay"),
              {7'd0, sda_out}, {7'd0, hist[t - d]});
        t++;
      end
      chk("R1 readback", reg_rdata, {c, 5'b0});
    end

    // R5: low bits written as ones read back zero
    wr(8'hBF); #1;
    chk("R5 low bits", reg_rdata, 8'hA0);

    // R3: one low-enable edge clears the code
    @(negedge clk); dig_en = 0; #1;
    chk("R6 closed read", reg_rdata, 8'h00);
    @(negedge clk); dig_en = 1; #1;
    chk("R3 cleared", reg_rdata, 8'h00);
    sda_in = ~sda_in; #1;
    chk("R3 bypass", {7'd0, sda_out}, {7'd0, sda_in});

    // R2: write while disabled is ignored
    @(negedge clk); dig_en = 0;
    wr(8'hE0);
    dig_en = 1; #1;
    chk("R2 locked write", reg_rdata, 8'h00);
    sda_in = ~sda_in; #1;
    chk("R2 still bypass", {7'd0, sda_out}, {7'd0, sda_in});

    // R2: enabled write works, then reset clears (R4)
    wr(8'h40); #1;
    chk("R2 open write", reg_rdata, 8'h40);
    rst_n = 0; #1; rst_n = 1; #1;
    chk("R4 after reset", reg_rdata, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule